// File: doc/BRIEF.md
# Four-Slot Issue Group Former

Each cycle the front end offers up to four decoded instructions in program order. Each one carries a valid bit and a 5-bit operation class. The block reports how many leading instructions form this cycle's issue group. The group is limited by the four issue slots and by the execution pipes: two integer ALUs, one memory/special pipe, one branch pipe, one FP add pipe and one FP multiply pipe. The front end retires `issue_cnt` instructions from the head of its window and offers the rest again next cycle. Only structural hazards are resolved here. Register dependencies and operand forwarding belong to other logic.

Long operations leave reservations behind. An integer multiply or divide locks every slot for a fixed number of later cycles. FP divide and square root keep the FP multiply pipe for a fixed number of later cycles. Each reservation is a two-state machine (`grp_hold_fsm`) with states ST_OPEN and ST_HELD. The transition *arm* (ST_OPEN to ST_HELD) happens when an issued group asks for a hold and loads the countdown. The transition *expire* (ST_HELD to ST_OPEN) happens on the last unstalled decrement. A stalled cycle keeps ST_HELD and freezes the count. Reset forces ST_OPEN. `busy` is high while either machine is in ST_HELD.

Top module: `grp_former`

## Requirements
- R1: Instructions are taken strictly in order, at most four per group. The first lane that is invalid or cannot get its resources ends the group, and `issue_cnt` counts the lanes before it. Lane i class is `lane_cls[5i+4:5i]`.
- R2: Class 0 (integer ALU, shift or compare) needs one of two ALUs, so at most two class-0 instructions issue per group.
- R3: Class 16 (single-issue: multi-part, window save/flush, cache flush, trap) issues only from lane 0 and alone (`issue_cnt`=1). In any later lane it ends the group. Codes 17 to 31 behave as class 16.
- R4: The memory/special pipe takes one instruction per group. It serves classes 1 load, 2 store, 3 integer conditional move, 4 integer multiply, 5 integer divide, 7 call/jump-and-link and 10 FP move on integer register.
- R5: The branch pipe takes one instruction per group. It serves classes 6 branch, 7 call, 3 integer conditional move and 9 FP move on condition code.
- R6: The FP add pipe takes one instruction per group and serves classes 8 FP move, 9, 10 and 11 FP add/compare/graphics add. The FP multiply pipe takes one instruction per group and serves classes 12 FP multiply/graphics multiply, 13, 14 and 15.
- R7: After class 4 issues, the next 4 unstalled cycles give `issue_cnt`=0 with `busy`=1. In the cycle after those, `busy`=0 and issue resumes.
- R8: After class 5 issues, the next 69 unstalled cycles give `issue_cnt`=0 with `busy`=1.
- R9: After class 13 (single divide) issues, the FP multiply pipe is reserved for 14 unstalled cycles. For class 14 (single square root, double divide) it is 17 cycles, and for class 15 (double square root) it is 26. During the reservation any class 12 to 15 ends the group, other classes still issue, and `busy`=1.
- R10: While `stall`=1, `issue_cnt`=0 and no countdown advances.
- R11: Reset (`rst_n`=0, synchronous) clears all reservations, so `busy`=0 and issue is unrestricted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| stall | input | 1 | Hold: no issue, countdowns frozen |
| lane_vld | input | 4 | Per-lane valid, lane 0 oldest |
| lane_cls | input | 20 | Per-lane 5-bit class, lane i at bits 5i+4:5i |
| issue_cnt | output | 3 | Number of leading lanes issued this cycle |
| busy | output | 1 | A slot or FP-multiply reservation is active |

## Verification
Every combination of classes, including an undefined code, is swept over the three oldest lanes. A pipe counted twice, a lane allowed past a blocked lane, or a single-issue class let through from a later lane would each change the count for some vector. Each countdown is walked cycle by cycle to its exact release edge. An off-by-one hold length shows as a wrong count or `busy` on the first or last cycle. A stall inserted mid-hold catches a counter that keeps running while stalled. The FP divide probe keeps an integer lane ahead of the FP multiply lane. That catches a reservation that wrongly blocks the whole group instead of only the pipe's users.

// File: rtl/grp_pkg.sv
package grp_pkg;

    localparam int CLS_W = 5;

    typedef enum logic [CLS_W-1:0] {
        C_IALU   = 5'd0,
        C_LOAD   = 5'd1,
        C_STORE  = 5'd2,
        C_ICMOV  = 5'd3,
        C_IMUL   = 5'd4,
        C_IDIV   = 5'd5,
        C_BRANCH = 5'd6,
        C_CALL   = 5'd7,
        C_FPMOV  = 5'd8,
        C_FCCMOV = 5'd9,
        C_FRCMOV = 5'd10,
        C_FADD   = 5'd11,
        C_FMUL   = 5'd12,
        C_FDIVS  = 5'd13,
        C_FMID   = 5'd14,
        C_FSQRTD = 5'd15,
        C_SOLO   = 5'd16
    } op_class_e;

    typedef enum logic [1:0] {H_NONE, H_MUL, H_DIV} slot_hold_e;
    typedef enum logic [1:0] {F_NONE, F_SHORT, F_MID, F_LONG} fpm_hold_e;

    typedef struct packed {
        logic       alu;
        logic       ms;
        logic       br;
        logic       fpa;
        logic       fpm;
        logic       solo;
        slot_hold_e shold;
        fpm_hold_e  fhold;
    } res_need_t;

endpackage

// File: rtl/grp_decode.sv
module grp_decode
    import grp_pkg::*;
(
    input  logic [CLS_W-1:0] cls,
    output res_need_t        need
);
    always_comb begin
        need       = '0;
        need.shold = H_NONE;
        need.fhold = F_NONE;
        case (cls)
            C_IALU:   need.alu = 1'b1;
            C_LOAD,
            C_STORE:  need.ms = 1'b1;
            C_ICMOV:  begin need.ms = 1'b1; need.br = 1'b1; end
            C_IMUL:   begin need.ms = 1'b1; need.shold = H_MUL; end
            C_IDIV:   begin need.ms = 1'b1; need.shold = H_DIV; end
            C_BRANCH: need.br = 1'b1;
            C_CALL:   begin need.br = 1'b1; need.ms = 1'b1; end
            C_FPMOV,
            C_FADD:   need.fpa = 1'b1;
            C_FCCMOV: begin need.fpa = 1'b1; need.br = 1'b1; end
            C_FRCMOV: begin need.fpa = 1'b1; need.ms = 1'b1; end
            C_FMUL:   need.fpm = 1'b1;
            C_FDIVS:  begin need.fpm = 1'b1; need.fhold = F_SHORT; end
            C_FMID:   begin need.fpm = 1'b1; need.fhold = F_MID; end
            C_FSQRTD: begin need.fpm = 1'b1; need.fhold = F_LONG; end
            default:  need.solo = 1'b1;
        endcase
    end
endmodule

// File: rtl/grp_pack.sv
module grp_pack
    import grp_pkg::*;
#(
    parameter int LANES   = 4,
    parameter int ALU_NUM = 2,
    localparam int CNT_W  = $clog2(LANES + 1)
) (
    input  logic [LANES-1:0]      vld,
    input  res_need_t [LANES-1:0] needs,
    input  logic                  stall,
    input  logic                  slot_held,
    input  logic                  fpm_held,
    output logic [CNT_W-1:0]      cnt,
    output slot_hold_e            go_shold,
    output fpm_hold_e             go_fhold
);
    logic [CNT_W-1:0] alu_n;
    logic             ms_u, br_u, fpa_u, fpm_u, stop, fit;

    always_comb begin
        cnt      = '0;
        alu_n    = '0;
        ms_u     = 1'b0;
        br_u     = 1'b0;
        fpa_u    = 1'b0;
        fpm_u    = 1'b0;
        fit      = 1'b0;
        stop     = stall | slot_held;
        go_shold = H_NONE;
        go_fhold = F_NONE;
        for (int i = 0; i < LANES; i++) begin
            fit = vld[i] && !stop
                  && !(needs[i].solo && i != 0)
                  && !(needs[i].alu && alu_n == CNT_W'(ALU_NUM))
                  && !(needs[i].ms  && ms_u)
                  && !(needs[i].br  && br_u)
                  && !(needs[i].fpa && fpa_u)
                  && !(needs[i].fpm && (fpm_u || fpm_held));
            if (fit) begin
                cnt   = cnt + CNT_W'(1);
                alu_n = alu_n + CNT_W'(needs[i].alu);
                ms_u  = ms_u  | needs[i].ms;
                br_u  = br_u  | needs[i].br;
                fpa_u = fpa_u | needs[i].fpa;
                fpm_u = fpm_u | needs[i].fpm;
                if (needs[i].shold != H_NONE) go_shold = needs[i].shold;
                if (needs[i].fhold != F_NONE) go_fhold = needs[i].fhold;
                if (needs[i].solo) stop = 1'b1;
            end else begin
                stop = 1'b1;
            end
        end
    end
endmodule

// File: rtl/grp_hold_fsm.sv
module grp_hold_fsm #(
    parameter int CW = 7
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          stall,
    input  logic          load,
    input  logic [CW-1:0] load_val,
    output logic          held
);
    typedef enum logic {ST_OPEN, ST_HELD} hold_st_e;

    hold_st_e      state, st_n;
    logic [CW-1:0] cnt, cnt_n;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ST_OPEN;
            cnt   <= '0;
        end else begin
            state <= st_n;
            cnt   <= cnt_n;
        end
    end

    always_comb begin
        st_n  = state;
        cnt_n = cnt;
        unique case (state)
            ST_OPEN: begin
                if (load && load_val != '0) begin
                    st_n  = ST_HELD;
                    cnt_n = load_val;
                end
            end
            ST_HELD: begin
                if (!stall) begin
                    cnt_n = cnt - CW'(1);
                    if (cnt == CW'(1)) st_n = ST_OPEN;
                end
            end
        endcase
    end

    always_comb held = (state == ST_HELD);

    // R7: the packer never asks for a new hold while one runs
    a_r7_load_only_open: assert property (@(posedge clk) disable iff (!rst_n)
        load |-> state == ST_OPEN);
    a_r10_stall_freeze: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_HELD && stall) |=> (state == ST_HELD && cnt == $past(cnt)));
    a_r8_step_down: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_HELD && !stall && cnt > CW'(1)) |=> (state == ST_HELD && cnt == $past(cnt) - CW'(1)));
endmodule

// File: rtl/grp_former.sv
module grp_former
    import grp_pkg::*;
#(
    parameter int LANES       = 4,
    parameter int ALU_NUM     = 2,
    parameter int MUL_HOLD    = 4,
    parameter int DIV_HOLD    = 69,
    parameter int FDIVS_HOLD  = 14,
    parameter int FMID_HOLD   = 17,
    parameter int FSQRTD_HOLD = 26,
    localparam int CNT_W      = $clog2(LANES + 1),
    localparam int SH_MAX     = (DIV_HOLD > MUL_HOLD) ? DIV_HOLD : MUL_HOLD,
    localparam int FH_MAX     = (FSQRTD_HOLD > FMID_HOLD) ?
                                ((FSQRTD_HOLD > FDIVS_HOLD) ? FSQRTD_HOLD : FDIVS_HOLD) :
                                ((FMID_HOLD > FDIVS_HOLD) ? FMID_HOLD : FDIVS_HOLD),
    localparam int SH_W       = $clog2(SH_MAX + 1),
    localparam int FH_W       = $clog2(FH_MAX + 1)
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   stall,
    input  logic [LANES-1:0]       lane_vld,
    input  logic [LANES*CLS_W-1:0] lane_cls,
    output logic [CNT_W-1:0]       issue_cnt,
    output logic                   busy
);
    res_need_t [LANES-1:0] needs;
    slot_hold_e            go_shold;
    fpm_hold_e             go_fhold;
    logic                  slot_held, fpm_held;
    logic [SH_W-1:0]       sh_val;
    logic [FH_W-1:0]       fh_val;

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        grp_decode u_dec (
            .cls  (lane_cls[g*CLS_W +: CLS_W]),
            .need (needs[g])
        );
    end

    grp_pack #(.LANES(LANES), .ALU_NUM(ALU_NUM)) u_pack (
        .vld       (lane_vld),
        .needs     (needs),
        .stall     (stall),
        .slot_held (slot_held),
        .fpm_held  (fpm_held),
        .cnt       (issue_cnt),
        .go_shold  (go_shold),
        .go_fhold  (go_fhold)
    );

    always_comb begin
        unique case (go_shold)
            H_MUL:   sh_val = SH_W'(MUL_HOLD);
            H_DIV:   sh_val = SH_W'(DIV_HOLD);
            default: sh_val = '0;
        endcase
        unique case (go_fhold)
            F_SHORT: fh_val = FH_W'(FDIVS_HOLD);
            F_MID:   fh_val = FH_W'(FMID_HOLD);
            F_LONG:  fh_val = FH_W'(FSQRTD_HOLD);
            default: fh_val = '0;
        endcase
    end

    grp_hold_fsm #(.CW(SH_W)) u_slot_hold (
        .clk      (clk),
        .rst_n    (rst_n),
        .stall    (stall),
        .load     (go_shold != H_NONE),
        .load_val (sh_val),
        .held     (slot_held)
    );

    grp_hold_fsm #(.CW(FH_W)) u_fpm_hold (
        .clk      (clk),
        .rst_n    (rst_n),
        .stall    (stall),
        .load     (go_fhold != F_NONE),
        .load_val (fh_val),
        .held     (fpm_held)
    );

    assign busy = slot_held | fpm_held;

    a_r1_group_bound: assert property (@(posedge clk) disable iff (!rst_n)
        issue_cnt <= CNT_W'(LANES));
    a_r7_no_issue_held: assert property (@(posedge clk) disable iff (!rst_n)
        slot_held |-> issue_cnt == '0);
    a_r10_stall_blocks: assert property (@(posedge clk) disable iff (!rst_n)
        stall |-> issue_cnt == '0);
    a_r3_solo_alone: assert property (@(posedge clk) disable iff (!rst_n)
        (needs[0].solo && issue_cnt != '0) |-> issue_cnt == CNT_W'(1));
    a_r9_hold_sets_busy: assert property (@(posedge clk) disable iff (!rst_n)
        (go_fhold != F_NONE) |=> busy);
endmodule

// File: tb/sim_grp_former.sv
module sim_grp_former;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        stall = 1'b0;
    logic [3:0]  lane_vld = '0;
    logic [19:0] lane_cls = '0;
    logic [2:0]  issue_cnt;
    logic        busy;
    int          errs = 0;
    int          checks = 0;

    always #2 clk = ~clk;

    grp_former u0 (
        .clk(clk), .rst_n(rst_n), .stall(stall),
        .lane_vld(lane_vld), .lane_cls(lane_cls),
        .issue_cnt(issue_cnt), .busy(busy)
    );

    function automatic logic [19:0] pk(int a, int b, int c, int d);
        return {d[4:0], c[4:0], b[4:0], a[4:0]};
    endfunction

    // expected group size from the class rules, no reservation active
    function automatic int model(logic [3:0] v, logic [19:0] cf);
        int n = 0;
        int alus = 0;
        bit ms = 0, br = 0, fa = 0, fm = 0;
        for (int i = 0; i < 4; i++) begin
            int c = int'(cf[5*i +: 5]);
            bit na = (c == 0);
            bit nm = (c == 1 || c == 2 || c == 3 || c == 4 || c == 5 || c == 7 || c == 10);
            bit nb = (c == 3 || c == 6 || c == 7 || c == 9);
            bit nf = (c >= 8 && c <= 11);
            bit np = (c >= 12 && c <= 15);
            if (!v[i]) break;
            if (c >= 16) begin
                if (i == 0) n = 1;
                break;
            end
            if ((na && alus == 2) || (nm && ms) || (nb && br) || (nf && fa) || (np && fm)) break;
            alus += int'(na);
            ms |= nm; br |= nb; fa |= nf; fm |= np;
            n++;
        end
        return n;
    endfunction

    task automatic apply(input logic [3:0] v, input logic [19:0] cf, input logic st,
                         input int ec, input int eb, input string tag, input bit rst_after);
        lane_vld = v;
        lane_cls = cf;
        stall    = st;
        @(negedge clk);
        checks++;
        if (int'(issue_cnt) != ec) begin
            errs++;
            $display("FAIL %s issue_cnt got %0d exp %0d (vld=%b cls=%h)", tag, issue_cnt, ec, v, cf);
        end
        if (eb >= 0) begin
            checks++;
            if (int'(busy) != eb) begin
                errs++;
                $display("FAIL %s busy got %0d exp %0d", tag, busy, eb);
            end
        end
        if (rst_after) rst_n = 1'b0;
        @(posedge clk);
        #1;
        rst_n = 1'b1;
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        lane_vld = '0;
        stall = 1'b0;
        @(posedge clk);
        @(posedge clk);
        #1;
        rst_n = 1'b1;
    endtask

    // lead op issues alone, then probe is offered every cycle
    task automatic hold_walk(input int lead, input int len, input logic [19:0] probe,
                             input int during, input int after, input int stall_at, input string tag);
        do_reset();
        apply(4'b0001, pk(lead, 0, 0, 0), 1'b0, 1, 0, tag, 1'b0);
        for (int k = 0; k < len; k++) begin
            if (k == stall_at) begin
                for (int s = 0; s < 3; s++)
                    apply(4'b1111, probe, 1'b1, 0, 1, "R10 stall in hold", 1'b0);
            end
            apply(4'b1111, probe, 1'b0, during, 1, tag, 1'b0);
        end
        apply(4'b1111, probe, 1'b0, after, 0, tag, 1'b0);
    endtask

    initial begin
        do_reset();
        // R11 reset state, R2 two ALUs
        apply(4'b1111, pk(0, 0, 0, 0), 1'b0, 2, 0, "R11 R2 after reset", 1'b0);
        // R10 stall with no reservation
        apply(4'b1111, pk(0, 1, 6, 11), 1'b1, 0, 0, "R10 stall", 1'b0);
        apply(4'b1111, pk(0, 1, 6, 11), 1'b0, 4, 0, "R1 full group", 1'b0);
        // R3 undefined code acts single-issue
        apply(4'b1111, pk(25, 0, 0, 0), 1'b0, 1, 0, "R3 undefined code", 1'b1);
        // R1 valid-pattern sweep
        for (int v = 0; v < 16; v++)
            apply(v[3:0], pk(0, 1, 6, 11), 1'b0, model(v[3:0], pk(0, 1, 6, 11)), 0, "R1 valid sweep", 1'b1);
        // R1 R2 R3 R4 R5 R6 class sweep over three lanes
        for (int a = 0; a < 18; a++)
            for (int b = 0; b < 18; b++)
                for (int c = 0; c < 18; c++) begin
                    logic [19:0] cf = pk(a, b, c, (a * 3 + b + c) % 18);
                    apply(4'b1111, cf, 1'b0, model(4'b1111, cf), -1, "R1 R2 R3 R4 R5 R6 sweep", 1'b1);
                end
        // R7 multiply hold, with a stall in the middle (R10)
        hold_walk(4, 4, pk(0, 0, 0, 0), 0, 2, 99, "R7 mul hold");
        hold_walk(4, 4, pk(0, 0, 0, 0), 0, 2, 2, "R7 R10 mul hold stalled");
        // R8 divide hold
        hold_walk(5, 69, pk(0, 0, 0, 0), 0, 2, 99, "R8 div hold");
        // R9 FP multiply pipe reservations: ALU ahead still issues
        hold_walk(13, 14, pk(0, 12, 0, 0), 1, 3, 99, "R9 fdivs hold");
        hold_walk(14, 17, pk(0, 12, 0, 0), 1, 3, 99, "R9 mid hold");
        hold_walk(15, 26, pk(0, 12, 0, 0), 1, 3, 99, "R9 fsqrtd hold");
        // R11 reset mid-hold
        do_reset();
        apply(4'b0001, pk(5, 0, 0, 0), 1'b0, 1, 0, "R8 div issue", 1'b0);
        apply(4'b1111, pk(0, 0, 0, 0), 1'b0, 0, 1, "R8 div held", 1'b0);
        do_reset();
        apply(4'b1111, pk(0, 0, 0, 0), 1'b0, 2, 0, "R11 reset clears hold", 1'b0);
        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end

    initial begin
        for (int cyc = 0; cyc < 190000; cyc++) @(posedge clk);
        errs++;
        checks++;
        $display("FAIL watchdog expired");
        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end
endmodule